// File: doc/BRIEF.md
# Countdown Load-Reservation Arbiter

This block keeps a single load-reserved / store-conditional reservation on behalf of a small group of cores. Each core offers a load-reserved request, a store-conditional request, an address and a one-cycle pulse for every instruction it retires. A core that asks for a reservation while none is held and nobody is waiting gets it on the next clock. It then has a budget of a fixed number of its own retired instructions in which to complete the pair.

Any other core that asks while a reservation is held is parked in an arrival-ordered queue, whatever address it names. Its stall output stays high until the holder either completes its store-conditional or spends its whole budget. The waiting core never disturbs the holder. When the reservation is released, either way, the oldest waiter takes it over on the same clock edge with a fresh budget. The address it gave when it joined the queue becomes the new reserved address.

Every store-conditional is answered one cycle later with a done pulse and a success flag. Only the current holder, naming the reserved address, can succeed.

Top module: `lrarb_top`

## Requirements
- R1: After synchronous reset, lr_grant, stall, sc_done and sc_ok are all 0 and no reservation is held.
- R2: A load-reserved request from a core that arrives while no reservation is held and no core is waiting pulses that core's lr_grant bit in the next cycle. If several arrive in the same cycle, the lowest core index is granted and the others raise stall in the next cycle.
- R3: A load-reserved request from a non-holding core while a reservation is held, to the same or a different address, raises that core's stall bit in the next cycle. It leaves the holder's reservation intact, so the holder's later store-conditional still succeeds.
- R4: The holder's budget is LIMIT (default 64) of its own retire pulses, loaded at grant. Retire pulses of other cores do not count.
- R5: A store-conditional from the holder, with req_addr equal to the reserved address, made before the budget runs out gives sc_done=1 and sc_ok=1 for that core in the next cycle. A store-conditional in the same cycle as the last budgeted retire pulse still succeeds.
- R6: On a release, the oldest waiter is granted on the same edge: its lr_grant pulses and its stall drops in the cycle that shows the holder's sc_ok. The new holder starts a full fresh budget.
- R7: When the holder's LIMIT-th retire pulse arrives without a successful store-conditional, the reservation lapses. The oldest waiter, if any, is granted in the next cycle, and a later store-conditional from the lapsed core gives sc_done=1 with sc_ok=0.
- R8: Waiters are granted oldest first, regardless of core index; cores that joined in the same cycle are ordered by lowest index.
- R9: A store-conditional from a core that is not the holder, or from the holder with a different address, gives sc_done=1 and sc_ok=0 in the next cycle and changes no state: the stall outputs keep their values and the holder's reservation remains.
- R10: A load-reserved request from a core that already holds the reservation or is already waiting is ignored: no lr_grant pulse, and the queue order is unchanged.
- R11: A release with no core waiting leaves the block free, so the next load-reserved request is granted at once as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_req | input | N | Load-reserved request, one bit per core |
| sc_req | input | N | Store-conditional request, one bit per core |
| retire | input | N | One pulse per retired instruction, one bit per core |
| req_addr | input | N*AW | Request address of core k in bits k*AW +: AW |
| lr_grant | output | N | One-cycle pulse: reservation granted to this core |
| stall | output | N | Core is waiting for the reservation |
| sc_done | output | N | One-cycle pulse answering a store-conditional |
| sc_ok | output | N | Store-conditional succeeded (valid with sc_done) |

## Verification
A corrupted holder index or reserved address shows up on the very next store-conditional: sc_ok comes back 0 for the true holder, or 1 for an intruder, one cycle after the request. A budget counter that loads or decrements wrongly moves the grant of a stalled core earlier or later than the LIMIT-th holder retire pulse. That error is visible as a misplaced lr_grant pulse and stall edge. A broken age order grants the wrong waiter at the first release after the corruption.

// File: rtl/lrarb_pkg.sv
package lrarb_pkg;
  localparam int MAX_CORES = 32;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lrarb_countdown.sv
module lrarb_countdown #(
  parameter int LIMIT = 64,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          dec,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= CW'(LIMIT);
    end else if (dec && count != '0) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/lrarb_age_queue.sv
module lrarb_age_queue #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] join_req,
  input  logic [N-1:0] leave,
  output logic [N-1:0] waiting,
  output logic [N-1:0] oldest
);
  // older[i][j] set: core i joined before core j
  logic [N-1:0] older [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= '0;
      for (int i = 0; i < N; i++) older[i] <= '0;
    end else begin
      waiting <= (waiting & ~leave) | join_req;
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (join_req[i] && join_req[j]) older[i][j] <= (i < j);
          else if (join_req[i])           older[i][j] <= 1'b0;
          else if (join_req[j])           older[i][j] <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pick
    logic [N-1:0] col;
    for (genvar j = 0; j < N; j++) begin : g_col
      assign col[j] = older[j][i];
    end
    assign oldest[i] = waiting[i] &
                       ~|(col & waiting & ~(N'(1) << i));
  end
endmodule

// File: rtl/lrarb_top.sv
module lrarb_top
  import lrarb_pkg::*;
#(
  parameter int N     = 3,
  parameter int AW    = 16,
  parameter int LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  lr_req,
  input  logic [N-1:0]  sc_req,
  input  logic [N-1:0]  retire,
  input  logic [N*AW-1:0] req_addr,
  output logic [N-1:0]  lr_grant,
  output logic [N-1:0]  stall,
  output logic [N-1:0]  sc_done,
  output logic [N-1:0]  sc_ok
);
  localparam int IW = idx_width(N);
  localparam int CW = $clog2(LIMIT + 1);

  logic          hold_v;
  logic [IW-1:0] hold_id;
  logic [AW-1:0] hold_addr;
  logic [AW-1:0] wait_addr [N];
  logic [AW-1:0] addr_of   [N];
  logic [CW-1:0] cnt;

  logic [N-1:0]  waiting, oldest, lr_new, holder_mask;
  logic [N-1:0]  grant_mask, join_req, leave;
  logic          sc_hit, expire, release_now, direct, from_q, grant_any;
  logic [IW-1:0] grant_id;
  logic [AW-1:0] grant_addr;

  for (genvar k = 0; k < N; k++) begin : g_addr
    assign addr_of[k] = req_addr[k*AW +: AW];
  end

  always_comb begin
    holder_mask = hold_v ? (N'(1) << hold_id) : '0;
    sc_hit      = hold_v && sc_req[hold_id] && (addr_of[hold_id] == hold_addr);
    expire      = hold_v && retire[hold_id] && (cnt == CW'(1));
    release_now = sc_hit || expire;
    lr_new      = lr_req & ~waiting & ~holder_mask;
    direct      = !hold_v && !(|waiting) && (|lr_new);
    from_q      = (|waiting) && (!hold_v || release_now);
    if (direct)      grant_mask = lr_new & (~lr_new + N'(1));
    else if (from_q) grant_mask = oldest;
    else             grant_mask = '0;
    join_req  = direct ? (lr_new & ~grant_mask) : lr_new;
    leave     = from_q ? oldest : '0;
    grant_any = |grant_mask;
    grant_id  = '0;
    for (int k = 0; k < N; k++) begin
      if (grant_mask[k]) grant_id = IW'(k);
    end
    grant_addr = direct ? addr_of[grant_id] : wait_addr[grant_id];
  end

  lrarb_age_queue #(.N(N)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .join_req (join_req),
    .leave    (leave),
    .waiting  (waiting),
    .oldest   (oldest)
  );

  lrarb_countdown #(.LIMIT(LIMIT), .CW(CW)) u_count (
    .clk   (clk),
    .rst   (rst),
    .load  (grant_any),
    .dec   (hold_v && retire[hold_id]),
    .count (cnt)
  );

  // Waiter address store: written on join, no reset needed
  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (join_req[k]) wait_addr[k] <= addr_of[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_id   <= '0;
      hold_addr <= '0;
      lr_grant  <= '0;
      sc_done   <= '0;
      sc_ok     <= '0;
    end else begin
      if (grant_any) begin
        hold_v    <= 1'b1;
        hold_id   <= grant_id;
        hold_addr <= grant_addr;
      end else if (release_now) begin
        hold_v    <= 1'b0;
      end
      lr_grant <= grant_mask;
      sc_done  <= sc_req;
      sc_ok    <= sc_hit ? holder_mask : '0;
    end
  end

  assign stall = waiting;
endmodule

// File: rtl/lrarb_chk.sv
module lrarb_chk #(
  parameter int N     = 3,
  parameter int LIMIT = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  lr_grant,
  input logic [N-1:0]  stall,
  input logic [N-1:0]  sc_done,
  input logic [N-1:0]  sc_ok,
  input logic          hold_v,
  input logic [CW-1:0] cnt
);
  p_one_grant_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lr_grant));

  p_one_ok_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sc_ok));

  p_ok_answered_r9: assert property (@(posedge clk) disable iff (rst)
    (sc_ok & ~sc_done) == '0);

  p_granted_not_stalled_r6: assert property (@(posedge clk) disable iff (rst)
    (lr_grant & stall) == '0);

  p_budget_live_r4: assert property (@(posedge clk) disable iff (rst)
    hold_v |-> (cnt != '0 && cnt <= CW'(LIMIT)));

  for (genvar i = 0; i < N; i++) begin : g_leave
    p_leave_by_grant_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(stall[i]) |-> lr_grant[i]);
  end
endmodule

bind lrarb_top lrarb_chk #(.N(N), .LIMIT(LIMIT), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lr_grant (lr_grant),
  .stall    (stall),
  .sc_done  (sc_done),
  .sc_ok    (sc_ok),
  .hold_v   (hold_v),
  .cnt      (cnt)
);

// File: tb/sim_lrarb_top.sv
`timescale 1ns/1ps
module sim_lrarb_top;
  localparam int N  = 3;
  localparam int AW = 8;
  localparam int LIM = 64;
  localparam logic [N*AW-1:0] ADR = {8'h20, 8'h10, 8'h10};
  localparam logic [N*AW-1:0] BAD = {8'h20, 8'h10, 8'h33};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] lr_req = '0, sc_req = '0, retire = '0;
  logic [N*AW-1:0] req_addr = ADR;
  logic [N-1:0] lr_grant, stall, sc_done, sc_ok;
  logic [N-1:0] g, st, sd, so;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lrarb_top #(.N(N), .AW(AW), .LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .lr_req(lr_req), .sc_req(sc_req),
    .retire(retire), .req_addr(req_addr), .lr_grant(lr_grant),
    .stall(stall), .sc_done(sc_done), .sc_ok(sc_ok)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] lr, input logic [N-1:0] sc,
                      input logic [N-1:0] rt, input logic [N*AW-1:0] ad);
    @(negedge clk);
    lr_req = lr; sc_req = sc; retire = rt; req_addr = ad;
    @(posedge clk);
    #1;
    g = lr_grant; st = stall; sd = sc_done; so = sc_ok;
  endtask

  task automatic idle();
    step('0, '0, '0, ADR);
  endtask

  task automatic t_reset();
    chk("R1 grant", 32'(lr_grant), 0);
    chk("R1 stall", 32'(stall), 0);
    chk("R1 done", 32'(sc_done), 0);
    chk("R1 ok", 32'(sc_ok), 0);
  endtask

  task automatic t_idle_grant();
    step(3'b001, '0, '0, ADR);
    chk("R2 direct grant", 32'(g), 32'b001);
    chk("R2 no stall", 32'(st), 0);
    step('0, 3'b001, '0, ADR);
    chk("R5 sc done", 32'(sd), 32'b001);
    chk("R5 sc ok", 32'(so), 32'b001);
    chk("R11 no grant on empty release", 32'(g), 0);
    step(3'b010, '0, '0, ADR);
    chk("R11 free again", 32'(g), 32'b010);
    step('0, 3'b010, '0, ADR);
    chk("R11 sc ok", 32'(so), 32'b010);
    idle();
  endtask

  task automatic t_sim_lr();
    step(3'b110, '0, '0, ADR);
    chk("R2 lowest wins", 32'(g), 32'b010);
    chk("R2 loser stalls", 32'(st), 32'b100);
    step('0, 3'b010, '0, ADR);
    chk("R6 sc ok", 32'(so), 32'b010);
    chk("R6 handover grant", 32'(g), 32'b100);
    chk("R6 stall drops", 32'(st), 0);
    step('0, 3'b100, '0, ADR);
    chk("R6 new holder ok", 32'(so), 32'b100);
    idle();
  endtask

  task automatic t_stall_keep();
    step(3'b001, '0, '0, ADR);
    chk("R2 grant c0", 32'(g), 32'b001);
    step(3'b010, '0, '0, ADR);
    chk("R3 same addr stalls", 32'(st), 32'b010);
    step(3'b100, '0, '0, ADR);
    chk("R3 other addr stalls", 32'(st), 32'b110);
    chk("R3 no grant", 32'(g), 0);
    step('0, 3'b010, '0, ADR);
    chk("R9 intruder done", 32'(sd), 32'b010);
    chk("R9 intruder fails", 32'(so), 0);
    chk("R9 stalls kept", 32'(st), 32'b110);
    step('0, 3'b001, '0, BAD);
    chk("R9 wrong addr done", 32'(sd), 32'b001);
    chk("R9 wrong addr fails", 32'(so), 0);
    chk("R9 wrong addr no grant", 32'(g), 0);
    step('0, 3'b001, '0, ADR);
    chk("R3 holder kept ok", 32'(so), 32'b001);
    chk("R8 first arrival granted", 32'(g), 32'b010);
    chk("R8 later still stalls", 32'(st), 32'b100);
    step('0, 3'b010, '0, ADR);
    chk("R8 next grant", 32'(g), 32'b100);
    step('0, 3'b100, '0, ADR);
    chk("R3 stored addr ok", 32'(so), 32'b100);
    idle();
  endtask

  task automatic t_order();
    step(3'b100, '0, '0, ADR);
    chk("R2 grant c2", 32'(g), 32'b100);
    step(3'b010, '0, '0, ADR);
    step(3'b001, '0, '0, ADR);
    chk("R8 both stall", 32'(st), 32'b011);
    step('0, 3'b100, '0, ADR);
    chk("R8 oldest not lowest", 32'(g), 32'b010);
    chk("R8 c0 waits", 32'(st), 32'b001);
    step('0, 3'b010, '0, ADR);
    chk("R8 then c0", 32'(g), 32'b001);
    step('0, 3'b001, '0, ADR);
    chk("R8 c0 ok", 32'(so), 32'b001);
    idle();
  endtask

  task automatic t_count();
    int seen = 0;
    step(3'b001, '0, '0, ADR);
    chk("R4 grant c0", 32'(g), 32'b001);
    step(3'b010, '0, '0, ADR);
    for (int k = 0; k < 70; k++) begin
      step('0, '0, 3'b010, ADR);
      if (g != 0) seen++;
    end
    chk("R4 foreign retires ignored", 32'(seen), 0);
    for (int k = 0; k < LIM - 1; k++) begin
      step('0, '0, 3'b001, ADR);
      if (g != 0) seen++;
    end
    chk("R4 no early lapse", 32'(seen), 0);
    chk("R4 still stalled", 32'(st), 32'b010);
    step('0, '0, 3'b001, ADR);
    chk("R7 lapse grants waiter", 32'(g), 32'b010);
    chk("R7 stall drops", 32'(st), 0);
    step('0, 3'b001, '0, ADR);
    chk("R7 late sc done", 32'(sd), 32'b001);
    chk("R7 late sc fails", 32'(so), 0);
    for (int k = 0; k < LIM - 1; k++) step('0, '0, 3'b010, ADR);
    step('0, 3'b010, 3'b010, ADR);
    chk("R5 sc on last retire ok", 32'(so), 32'b010);
    chk("R6 fresh budget", 32'(sd), 32'b010);
    idle();
  endtask

  task automatic t_ignore();
    step(3'b001, '0, '0, ADR);
    chk("R10 grant c0", 32'(g), 32'b001);
    step(3'b010, '0, '0, ADR);
    step(3'b100, '0, '0, ADR);
    step(3'b111, '0, '0, ADR);
    chk("R10 repeat no grant", 32'(g), 0);
    chk("R10 stalls unchanged", 32'(st), 32'b110);
    step('0, 3'b001, '0, ADR);
    chk("R10 holder ok", 32'(so), 32'b001);
    chk("R10 order kept", 32'(g), 32'b010);
    step('0, 3'b010, '0, ADR);
    chk("R10 then c2", 32'(g), 32'b100);
    step('0, 3'b100, '0, ADR);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    idle();
    t_idle_grant();
    t_sim_lr();
    t_stall_keep();
    t_order();
    t_count();
    t_ignore();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired R1 got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule